// File: doc/BRIEF.md
# Dual Byte Queue Controller with DMA Request Outputs

This block sits between a serial transceiver and the system bus. It holds two byte queues of 32 entries each: one for bytes waiting to be sent and one for bytes that have arrived. A single 8-bit configuration write port turns the queues on, selects the fill thresholds for each direction, and can empty either queue with a one-shot command. Two active-low request outputs tell a DMA controller when to move data. In simple signalling each output follows plain empty or non-empty state. In block signalling each output uses its threshold, and once set it is held until an opposite event clears it, so the DMA controller moves bursts instead of single bytes.

The transmit serializer pops from the transmit queue and the receive deserializer pushes into the receive queue. The CPU or DMA side pushes transmit bytes and pops receive bytes. An external timeout detector pulses `rx_timeout` when bytes have been sitting in the receive queue too long. Both queue fill levels are brought out so the surrounding logic can observe them.

Configuration byte fields: bit 0 is queue enable, bit 1 is the receive flush command, bit 2 is the transmit flush command, bit 3 selects block signalling, bits [5:4] select the transmit threshold and bits [7:6] select the receive threshold.

Top module: `uart_fifo_dma`

## Requirements
- R1: Each queue holds 32 bytes and returns them in first-in first-out order. A pop updates the read data output at the pop clock edge. A push to a full queue is dropped, the level stays at 32, and the matching overflow output is 1 for exactly the following cycle.
- R2: A pop from an empty queue leaves the read data output unchanged and the level at 0.
- R3: A configuration write with bit 0 = 0 only turns the queues off, which forces simple signalling. Its flush bits (bit 1 and bit 2) have no effect, and neither queue level changes.
- R4: A configuration write with bit 0 = 1 and bit 1 = 1 sets the receive level to 0 at that edge. The transmit queue is untouched. The command does not persist, so a push in the next cycle is accepted.
- R5: A configuration write with bit 0 = 1 and bit 2 = 1 sets the transmit level to 0 at that edge. The receive queue is untouched, and the command does not persist.
- R6: The receive threshold comes from bits [7:6]: 00 gives 8 bytes, 01 gives 16, 10 gives 24 and 11 gives 28.
- R7: The transmit threshold comes from bits [5:4]: 00 gives 16 free entries, 01 gives 8, 10 gives 24 and 11 gives 30.
- R8: In simple signalling (bit 0 = 0 or bit 3 = 0), `rx_dma_req_n` is 0 exactly when the receive level is at least 1.
- R9: In simple signalling, `tx_dma_req_n` is 0 exactly when the transmit level is 0.
- R10: In block signalling (bit 0 = 1 and bit 3 = 1), `rx_dma_req_n` goes to 0 when the receive level reaches the threshold. It also goes to 0 in the cycle after an `rx_timeout` pulse, if the queue is not empty. It then stays 0 until the receive level is 0, and then goes to 1.
- R11: In block signalling, `tx_dma_req_n` is 1 while the transmit queue is full. It is 0 while the number of free entries is at least the threshold. Otherwise it holds its previous value.
- R12: After reset all configuration bits are 0, both levels are 0, both overflow outputs are 0, `tx_dma_req_n` is 0 and `rx_dma_req_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration write data |
| tx_push | input | 1 | Push a byte into the transmit queue |
| tx_wdata | input | 8 | Byte to push into the transmit queue |
| tx_pop | input | 1 | Pop a byte from the transmit queue |
| tx_rdata | output | 8 | Last byte popped from the transmit queue |
| tx_overflow | output | 1 | One-cycle flag: a transmit push was dropped |
| tx_level | output | 6 | Transmit queue fill level |
| tx_dma_req_n | output | 1 | Transmit DMA request, active low |
| rx_push | input | 1 | Push a byte into the receive queue |
| rx_wdata | input | 8 | Byte to push into the receive queue |
| rx_pop | input | 1 | Pop a byte from the receive queue |
| rx_rdata | output | 8 | Last byte popped from the receive queue |
| rx_overflow | output | 1 | One-cycle flag: a receive push was dropped |
| rx_level | output | 6 | Receive queue fill level |
| rx_timeout | input | 1 | Receive timeout pulse from outside |
| rx_dma_req_n | output | 1 | Receive DMA request, active low |

## Verification
The receive queue is filled one byte at a time from empty to full, then drained to empty, once for every receive threshold code. This places each code's switch point at a distinct level, so a wrong decode or an early release shows up. The same full sweep is run on the transmit queue for every transmit threshold code, compared with a model that holds its state between events, which separates holding from plain threshold tracking. Simple signalling is swept with the queues both off and on but with bit 3 clear. Shorter patterns cover the flush commands with and without bit 0, timeout pulses into an empty and into a partly filled queue, and pushes into a full queue and pops from an empty one.

// File: rtl/ufd_pkg.sv
package ufd_pkg;

   typedef struct packed {
      logic [1:0] rx_sel;
      logic [1:0] tx_sel;
      logic       dma_mode;
      logic       on;
   } ufd_cfg_t;

   // receive threshold in bytes held, scaled to queue depth
   function automatic int rx_trig_lvl(input int depth, input logic [1:0] sel);
      int r;
      case (sel)
         2'd0:    r = depth / 4;
         2'd1:    r = depth / 2;
         2'd2:    r = (3 * depth) / 4;
         default: r = depth - depth / 8;
      endcase
      return r;
   endfunction

   // transmit threshold in free entries, scaled to queue depth
   function automatic int tx_trig_lvl(input int depth, input logic [1:0] sel);
      int r;
      case (sel)
         2'd0:    r = depth / 2;
         2'd1:    r = depth / 4;
         2'd2:    r = (3 * depth) / 4;
         default: r = depth - depth / 16;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/ufd_cfg_reg.sv
module ufd_cfg_reg
   import ufd_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       we,
   input  logic [7:0] wdata,
   output ufd_cfg_t   cfg,
   output logic       rx_flush,
   output logic       tx_flush
);

   // flush commands act for the write cycle only; nothing is stored
   assign rx_flush = we && wdata[0] && wdata[1];
   assign tx_flush = we && wdata[0] && wdata[2];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg <= '0;
      end else if (we) begin
         if (wdata[0]) begin
            cfg.rx_sel   <= wdata[7:6];
            cfg.tx_sel   <= wdata[5:4];
            cfg.dma_mode <= wdata[3];
            cfg.on       <= 1'b1;
         end else begin
            cfg.on <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/ufd_byte_fifo.sv
module ufd_byte_fifo #(
   parameter int DEPTH = 32,
   parameter int DW    = 8,
   localparam int LW   = $clog2(DEPTH + 1),
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flush,
   input  logic          push,
   input  logic [DW-1:0] wdata,
   input  logic          pop,
   output logic [DW-1:0] rdata,
   output logic          overflow,
   output logic [LW-1:0] level
);

   localparam logic [LW-1:0] FULL = LW'(DEPTH);

   logic [DW-1:0] mem [DEPTH];
   logic [AW-1:0] wp, rp;
   logic          do_push, do_pop;

   assign do_push = push && (level != FULL);
   assign do_pop  = pop && (level != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp       <= '0;
         rp       <= '0;
         level    <= '0;
         rdata    <= '0;
         overflow <= 1'b0;
      end else if (flush) begin
         wp       <= '0;
         rp       <= '0;
         level    <= '0;
         overflow <= 1'b0;
      end else begin
         overflow <= push && !do_push;
         if (do_push) wp <= wp + 1'b1;
         if (do_pop) begin
            rp    <= rp + 1'b1;
            rdata <= mem[rp];
         end
         level <= level + LW'(do_push) - LW'(do_pop);
      end
   end

   always_ff @(posedge clk) begin
      if (!flush && do_push) mem[wp] <= wdata;
   end

endmodule

// File: rtl/ufd_rx_ready.sv
module ufd_rx_ready
   import ufd_pkg::*;
#(
   parameter int DEPTH = 32,
   localparam int LW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          mode1,
   input  logic [LW-1:0] level,
   input  logic [1:0]    sel,
   input  logic          timeout,
   output logic          req_n
);

   localparam int CW = LW + 1;

   logic [CW-1:0] trig;
   logic          not_empty, hit, latch_q;

   assign trig      = CW'(rx_trig_lvl(DEPTH, sel));
   assign not_empty = (level != '0);
   assign hit       = ({1'b0, level} >= trig);

   // once raised, kept until the queue drains
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) latch_q <= 1'b0;
      else        latch_q <= not_empty && (latch_q || hit || timeout);
   end

   assign req_n = mode1 ? !(not_empty && (latch_q || hit)) : !not_empty;

endmodule

// File: rtl/ufd_tx_ready.sv
module ufd_tx_ready
   import ufd_pkg::*;
#(
   parameter int DEPTH = 32,
   localparam int LW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          mode1,
   input  logic [LW-1:0] level,
   input  logic [1:0]    sel,
   output logic          req_n
);

   localparam int CW = LW + 1;
   localparam logic [LW-1:0] FULL = LW'(DEPTH);

   logic [CW-1:0] trig, free_cnt;
   logic          full, hit, hold_q, blk_state;

   assign trig      = CW'(tx_trig_lvl(DEPTH, sel));
   assign free_cnt  = CW'(DEPTH) - {1'b0, level};
   assign full      = (level == FULL);
   assign hit       = (free_cnt >= trig);
   assign blk_state = full ? 1'b1 : (hit ? 1'b0 : hold_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hold_q <= 1'b0;
      else        hold_q <= blk_state;
   end

   assign req_n = mode1 ? blk_state : (level != '0);

endmodule

// File: rtl/uart_fifo_dma.sv
module uart_fifo_dma
   import ufd_pkg::*;
#(
   parameter int DEPTH = 32,
   parameter int DW    = 8,
   localparam int LW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cfg_we,
   input  logic [7:0]    cfg_wdata,
   input  logic          tx_push,
   input  logic [DW-1:0] tx_wdata,
   input  logic          tx_pop,
   output logic [DW-1:0] tx_rdata,
   output logic          tx_overflow,
   output logic [LW-1:0] tx_level,
   output logic          tx_dma_req_n,
   input  logic          rx_push,
   input  logic [DW-1:0] rx_wdata,
   input  logic          rx_pop,
   output logic [DW-1:0] rx_rdata,
   output logic          rx_overflow,
   output logic [LW-1:0] rx_level,
   input  logic          rx_timeout,
   output logic          rx_dma_req_n
);

   generate
      if ((DEPTH < 16) || ((DEPTH & (DEPTH - 1)) != 0)) begin : g_bad_depth
         $error("uart_fifo_dma: DEPTH must be a power of two of at least 16");
      end
      if (DW < 1) begin : g_bad_width
         $error("uart_fifo_dma: DW must be at least 1");
      end
   endgenerate

   ufd_cfg_t cfg;
   logic     rx_flush, tx_flush, mode1;

   ufd_cfg_reg i_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .we       (cfg_we),
      .wdata    (cfg_wdata),
      .cfg      (cfg),
      .rx_flush (rx_flush),
      .tx_flush (tx_flush)
   );

   assign mode1 = cfg.on && cfg.dma_mode;

   ufd_byte_fifo #(.DEPTH(DEPTH), .DW(DW)) i_tx_q (
      .clk      (clk),
      .rst_n    (rst_n),
      .flush    (tx_flush),
      .push     (tx_push),
      .wdata    (tx_wdata),
      .pop      (tx_pop),
      .rdata    (tx_rdata),
      .overflow (tx_overflow),
      .level    (tx_level)
   );

   ufd_byte_fifo #(.DEPTH(DEPTH), .DW(DW)) i_rx_q (
      .clk      (clk),
      .rst_n    (rst_n),
      .flush    (rx_flush),
      .push     (rx_push),
      .wdata    (rx_wdata),
      .pop      (rx_pop),
      .rdata    (rx_rdata),
      .overflow (rx_overflow),
      .level    (rx_level)
   );

   ufd_tx_ready #(.DEPTH(DEPTH)) i_tx_rdy (
      .clk   (clk),
      .rst_n (rst_n),
      .mode1 (mode1),
      .level (tx_level),
      .sel   (cfg.tx_sel),
      .req_n (tx_dma_req_n)
   );

   ufd_rx_ready #(.DEPTH(DEPTH)) i_rx_rdy (
      .clk     (clk),
      .rst_n   (rst_n),
      .mode1   (mode1),
      .level   (rx_level),
      .sel     (cfg.rx_sel),
      .timeout (rx_timeout),
      .req_n   (rx_dma_req_n)
   );

endmodule

// File: rtl/uart_fifo_dma_chk.sv
module uart_fifo_dma_chk #(
   parameter int DEPTH = 32,
   parameter int DW    = 8,
   localparam int LW   = $clog2(DEPTH + 1)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          cfg_we,
   input logic [7:0]    cfg_wdata,
   input logic          tx_push,
   input logic          tx_pop,
   input logic          tx_overflow,
   input logic [LW-1:0] tx_level,
   input logic          tx_dma_req_n,
   input logic          rx_push,
   input logic          rx_pop,
   input logic [DW-1:0] rx_rdata,
   input logic [LW-1:0] rx_level,
   input logic          rx_dma_req_n
);

   localparam logic [LW-1:0] FULL = LW'(DEPTH);

   assert_level_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_level <= FULL) && (rx_level <= FULL));

   assert_no_overflow_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_push && !tx_pop && tx_level == FULL && !(cfg_we && cfg_wdata[0] && cfg_wdata[2]))
      |=> (tx_overflow && tx_level == FULL));

   assert_empty_pop_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_pop && !rx_push && rx_level == '0 && !(cfg_we && cfg_wdata[0]))
      |=> ($stable(rx_rdata) && rx_level == '0));

   assert_off_write_keeps_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && !cfg_wdata[0] && !rx_push && !rx_pop) |=> $stable(rx_level));

   assert_rx_flush_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_wdata[0] && cfg_wdata[1]) |=> (rx_level == '0));

   assert_tx_flush_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_wdata[0] && cfg_wdata[2]) |=> (tx_level == '0));

   assert_rx_idle_empty_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_level == '0) |-> rx_dma_req_n);

   assert_tx_full_high_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_level == FULL) |-> tx_dma_req_n);

endmodule

bind uart_fifo_dma uart_fifo_dma_chk #(.DEPTH(DEPTH), .DW(DW)) i_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .cfg_we       (cfg_we),
   .cfg_wdata    (cfg_wdata),
   .tx_push      (tx_push),
   .tx_pop       (tx_pop),
   .tx_overflow  (tx_overflow),
   .tx_level     (tx_level),
   .tx_dma_req_n (tx_dma_req_n),
   .rx_push      (rx_push),
   .rx_pop       (rx_pop),
   .rx_rdata     (rx_rdata),
   .rx_level     (rx_level),
   .rx_dma_req_n (rx_dma_req_n)
);

// File: tb/test_uart_fifo_dma.sv
module test_uart_fifo_dma;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_we = 1'b0;
   logic [7:0] cfg_wdata = '0;
   logic       tx_push = 1'b0, tx_pop = 1'b0;
   logic [7:0] tx_wdata = '0;
   logic [7:0] tx_rdata;
   logic       tx_overflow, tx_dma_req_n;
   logic [5:0] tx_level;
   logic       rx_push = 1'b0, rx_pop = 1'b0, rx_timeout = 1'b0;
   logic [7:0] rx_wdata = '0;
   logic [7:0] rx_rdata;
   logic       rx_overflow, rx_dma_req_n;
   logic [5:0] rx_level;

   int n_chk = 0;
   int n_err = 0;

   always #5 clk = ~clk;

   uart_fifo_dma i_uart_fifo_dma (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
      .tx_push(tx_push), .tx_wdata(tx_wdata), .tx_pop(tx_pop),
      .tx_rdata(tx_rdata), .tx_overflow(tx_overflow), .tx_level(tx_level),
      .tx_dma_req_n(tx_dma_req_n), .rx_push(rx_push), .rx_wdata(rx_wdata),
      .rx_pop(rx_pop), .rx_rdata(rx_rdata), .rx_overflow(rx_overflow),
      .rx_level(rx_level), .rx_timeout(rx_timeout), .rx_dma_req_n(rx_dma_req_n)
   );

   task automatic chk(input int act, input int exp, input string what);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual %0d expected %0d", what, act, exp);
      end
   endtask

   task automatic wr_cfg(input logic [7:0] v);
      cfg_we = 1'b1; cfg_wdata = v;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic rx_in(input logic [7:0] b);
      rx_push = 1'b1; rx_wdata = b;
      @(negedge clk);
      rx_push = 1'b0;
   endtask

   task automatic rx_out();
      rx_pop = 1'b1;
      @(negedge clk);
      rx_pop = 1'b0;
   endtask

   task automatic tx_in(input logic [7:0] b);
      tx_push = 1'b1; tx_wdata = b;
      @(negedge clk);
      tx_push = 1'b0;
   endtask

   task automatic tx_out();
      tx_pop = 1'b1;
      @(negedge clk);
      tx_pop = 1'b0;
   endtask

   function automatic int rx_thr(input int sel);
      return (sel == 3) ? 28 : 8 * (sel + 1);
   endfunction

   function automatic int tx_thr(input int sel);
      return (sel == 0) ? 16 : (sel == 1) ? 8 : (sel == 2) ? 24 : 30;
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      int hold;
      int exp;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R12 reset state
      chk(tx_level, 0, "R12 tx level");
      chk(rx_level, 0, "R12 rx level");
      chk(tx_dma_req_n, 0, "R12 tx req");
      chk(rx_dma_req_n, 1, "R12 rx req");
      chk(tx_overflow | rx_overflow, 0, "R12 overflow");

      // R1 R8: receive queue with queues off
      for (int i = 1; i <= 32; i++) begin
         rx_in(8'(i * 7 + 3));
         chk(rx_level, i, "R1 rx level fill");
         chk(rx_dma_req_n, 0, "R8 rx req simple");
      end
      rx_in(8'hEE);
      chk(rx_overflow, 1, "R1 rx overflow");
      chk(rx_level, 32, "R1 rx level kept");
      @(negedge clk);
      chk(rx_overflow, 0, "R1 rx overflow one cycle");
      for (int i = 1; i <= 32; i++) begin
         rx_out();
         chk(rx_rdata, (i * 7 + 3) & 255, "R1 rx order");
         chk(rx_dma_req_n, (i == 32) ? 1 : 0, "R8 rx req drain");
      end
      rx_out();
      chk(rx_rdata, (32 * 7 + 3) & 255, "R2 rx empty pop data");
      chk(rx_level, 0, "R2 rx empty pop level");

      // R1 R9: transmit queue, enabled with simple signalling
      wr_cfg(8'h01);
      for (int i = 1; i <= 32; i++) begin
         tx_in(8'(i * 13 + 1));
         chk(tx_dma_req_n, 1, "R9 tx req nonempty");
      end
      tx_in(8'h55);
      chk(tx_overflow, 1, "R1 tx overflow");
      chk(tx_level, 32, "R1 tx level kept");
      for (int i = 1; i <= 32; i++) begin
         tx_out();
         chk(tx_rdata, (i * 13 + 1) & 255, "R1 tx order");
         chk(tx_dma_req_n, (i == 32) ? 0 : 1, "R9 tx req drain");
      end
      tx_out();
      chk(tx_rdata, (32 * 13 + 1) & 255, "R2 tx empty pop data");
      chk(tx_level, 0, "R2 tx empty pop level");

      // R3 R4 R5: flush commands
      for (int i = 0; i < 5; i++) rx_in(8'(i));
      for (int i = 0; i < 3; i++) tx_in(8'(i));
      wr_cfg(8'h06);
      chk(rx_level, 5, "R3 rx flush ignored");
      chk(tx_level, 3, "R3 tx flush ignored");
      wr_cfg(8'h03);
      chk(rx_level, 0, "R4 rx flushed");
      chk(tx_level, 3, "R4 tx untouched");
      rx_in(8'h44);
      chk(rx_level, 1, "R4 push after flush");
      wr_cfg(8'h05);
      chk(tx_level, 0, "R5 tx flushed");
      chk(rx_level, 1, "R5 rx untouched");
      tx_in(8'h33);
      chk(tx_level, 1, "R5 push after flush");
      wr_cfg(8'h07);
      chk(rx_level + tx_level, 0, "R4 R5 both flushed");

      // R6 R10: receive thresholds in block signalling
      for (int s = 0; s < 4; s++) begin
         wr_cfg({2'(s), 2'b00, 4'b1011});
         chk(rx_dma_req_n, 1, "R10 rx req empty");
         for (int i = 1; i <= 32; i++) begin
            rx_in(8'(i));
            chk(rx_dma_req_n, (i >= rx_thr(s)) ? 0 : 1, "R6 rx threshold fill");
         end
         for (int i = 31; i >= 0; i--) begin
            rx_out();
            chk(rx_dma_req_n, (i == 0) ? 1 : 0, "R10 rx held until empty");
         end
      end

      // R3: disabling forces simple signalling (threshold 28 still selected)
      rx_in(8'h01);
      rx_in(8'h02);
      chk(rx_dma_req_n, 1, "R10 below threshold");
      wr_cfg(8'h00);
      chk(rx_dma_req_n, 0, "R3 off gives simple rx req");

      // R10: timeout
      wr_cfg(8'hCB);
      rx_timeout = 1'b1;
      @(negedge clk);
      rx_timeout = 1'b0;
      @(negedge clk);
      chk(rx_dma_req_n, 1, "R10 timeout on empty queue");
      for (int i = 0; i < 3; i++) rx_in(8'(i));
      chk(rx_dma_req_n, 1, "R10 before timeout");
      rx_timeout = 1'b1;
      @(negedge clk);
      rx_timeout = 1'b0;
      chk(rx_dma_req_n, 0, "R10 after timeout");
      rx_out();
      rx_out();
      chk(rx_dma_req_n, 0, "R10 timeout held");
      rx_out();
      chk(rx_dma_req_n, 1, "R10 released at empty");

      // R7 R11: transmit thresholds in block signalling
      for (int s = 0; s < 4; s++) begin
         wr_cfg({2'b00, 2'(s), 4'b1101});
         hold = 0;
         chk(tx_dma_req_n, 0, "R11 tx req empty");
         for (int i = 1; i <= 32; i++) begin
            tx_in(8'(i));
            exp = (i == 32) ? 1 : ((32 - i) >= tx_thr(s)) ? 0 : hold;
            hold = exp;
            chk(tx_dma_req_n, exp, "R7 R11 tx fill");
         end
         for (int i = 31; i >= 0; i--) begin
            tx_out();
            exp = ((32 - i) >= tx_thr(s)) ? 0 : hold;
            hold = exp;
            chk(tx_dma_req_n, exp, "R7 R11 tx drain");
         end
      end

      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

endmodule